// File: doc/BRIEF.md
# Word-Serial Big-Integer Multiply Accelerator

This block multiplies two unsigned integers of N bits each and leaves the 2N-bit product in memory. It sits on a simple word-wide register bus. Software loads the first operand into the low half of the X operand window. It loads the second operand into the high half of the Z window. It then writes a length code into the mode register and writes 1 to the start register. Each operand occupies a double-length region of n̂ = 2n words, where n is the operand length in 32-bit words. Word 0 is the least significant word.

The engine forms the product with the schoolbook method, one word at a time. It uses one 32×32 multiplier, a carry register and a private accumulation buffer. Only after every partial product has been summed does it copy the buffer over the first n̂ words of the Z window, because Z holds the second operand until that point. Completion sets a sticky flag. The flag drives a level interrupt through an enable bit. The length granule is a parameter (SEG_WORDS words). It is kept small so that simulation stays short.

Top module: `bigmul_accel`

## Requirements
- R1: After reset, the mode register reads 0, the completion flag reads 0, the interrupt enable reads 1 and irq is low.
- R2: The mode register at byte offset 0x0C holds wr_data[3:0] and reads back what was written. It keeps its value through and after an operation.
- R3: With mode = 8 + s (s < MAX_SEGS), n̂ = (s+1)·SEG_WORDS and n = n̂/2. X is taken from X-window words 0..n−1 (window base 0x400, stride 4). Y is taken from Z-window words n..n̂−1 (window base 0x800). After completion, Z words 0..n̂−1 hold X·Y, least significant word first.
- R4: Writing a value with bit 0 set to offset 0x10 starts an operation when the block is idle. This register always reads 0.
- R5: The completion flag at offset 0x14 reads 1 once the product is in Z. Writing 1 to it clears it, and an accepted start also clears it.
- R6: irq equals the completion flag ANDed with the enable bit at offset 0x08 bit 0. irq is never high while the engine is busy.
- R7: While an operation runs, writes to the X window, the Z window, the mode register and the start register are ignored.
- R8: A start is ignored when mode bit 3 is clear or when mode[2:0] ≥ MAX_SEGS. The flag then stays 0.
- R9: X words n..n̂−1, Z words 0..n−1 and all words at or beyond n̂ have no effect on the product. Z words at or beyond n̂ keep their contents.
- R10: rd_data shows the location addressed by rd_addr one clock earlier. Register offsets with no register behind them read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, one cycle after rd_addr |
| irq | output | 1 | Level interrupt: completion flag AND enable |

## Verification
The hardest case to reach from the ports is a bus write that lands while the engine is still accumulating. Such a write would corrupt an operand or the length mid-run if the block honoured it. The stimulus uses the longest length code, so the run spans about forty cycles. Right after the start it issues writes to X word 0, to a Y word, to the mode register and to the start register. The bench then requires the untouched product, the original mode and the original X word. Junk placed in every unused word and above n̂ shows that the engine reads only the words the length code selects.

// File: rtl/bigmul_pkg.sv
package bigmul_pkg;
  typedef logic [31:0] word_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_FETCH,
    ENG_MAC,
    ENG_COPY
  } eng_state_e;

  // address region selector (top two address bits)
  localparam logic [1:0] REGION_REG = 2'd0;
  localparam logic [1:0] REGION_X   = 2'd1;
  localparam logic [1:0] REGION_Z   = 2'd2;
endpackage

// File: rtl/bigmul_wordram.sv
module bigmul_wordram #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bigmul_engine.sv
module bigmul_engine
  import bigmul_pkg::*;
#(
  parameter int MEM_WORDS = 8,
  parameter int MW        = 3,
  parameter int NW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] nh_words,
  input  word_t         x_rdata,
  input  word_t         y_rdata,
  output logic [MW-1:0] x_raddr,
  output logic [MW-1:0] y_raddr,
  output logic          z_we,
  output logic [MW-1:0] z_waddr,
  output word_t         z_wdata,
  output logic          busy,
  output logic          done
);
  eng_state_e    state;
  logic [MW-1:0] i_q, j_q, k_q;
  word_t         carry_q;
  word_t         acc [MEM_WORDS];
  logic [NW-1:0] half;
  logic [MW-1:0] half_m;
  logic [MW-1:0] last_idx;
  logic          last_j, last_i, last_k;
  logic [63:0]   sum;

  assign half     = nh_words >> 1;
  assign half_m   = MW'(half);
  assign last_idx = MW'(half - NW'(1));
  assign last_j   = (j_q == last_idx);
  assign last_i   = (i_q == last_idx);
  assign last_k   = (k_q == MW'(nh_words - NW'(1)));

  assign x_raddr = i_q;
  assign y_raddr = half_m + j_q;
  assign sum = ({32'd0, x_rdata} * {32'd0, y_rdata})
             + {32'd0, acc[i_q + j_q]} + {32'd0, carry_q};

  assign z_we    = (state == ENG_COPY);
  assign z_waddr = k_q;
  assign z_wdata = acc[k_q];
  assign busy    = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      i_q     <= '0;
      j_q     <= '0;
      k_q     <= '0;
      carry_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ENG_IDLE: if (start) begin
          i_q     <= '0;
          j_q     <= '0;
          carry_q <= '0;
          state   <= ENG_FETCH;
        end
        ENG_FETCH: state <= ENG_MAC;
        ENG_MAC: begin
          if (last_j) begin
            carry_q <= '0;
            j_q     <= '0;
            if (last_i) begin
              k_q   <= '0;
              state <= ENG_COPY;
            end else begin
              i_q   <= i_q + MW'(1);
              state <= ENG_FETCH;
            end
          end else begin
            carry_q <= sum[63:32];
            j_q     <= j_q + MW'(1);
            state   <= ENG_FETCH;
          end
        end
        ENG_COPY: begin
          k_q <= k_q + MW'(1);
          if (last_k) begin
            state <= ENG_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // accumulation buffer: no reset, cleared at start
  always_ff @(posedge clk) begin
    if (state == ENG_IDLE && start) begin
      for (int m = 0; m < MEM_WORDS; m++) acc[m] <= '0;
    end else if (state == ENG_MAC) begin
      acc[i_q + j_q] <= sum[31:0];
      if (last_j) acc[i_q + half_m] <= sum[63:32];
    end
  end
endmodule

// File: rtl/bigmul_accel.sv
module bigmul_accel
  import bigmul_pkg::*;
#(
  parameter int SEG_WORDS = 4,
  parameter int MAX_SEGS  = 2,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam int MEM_WORDS = SEG_WORDS * MAX_SEGS;
  localparam int MW        = $clog2(MEM_WORDS);
  localparam int NW        = $clog2(MEM_WORDS + 1);
  localparam int OW        = ADDR_W - 2;
  localparam logic [OW-1:0] OFF_IEN  = OW'(8);
  localparam logic [OW-1:0] OFF_MODE = OW'(12);
  localparam logic [OW-1:0] OFF_GO   = OW'(16);
  localparam logic [OW-1:0] OFF_DONE = OW'(20);

  logic [3:0]    mode_q;
  logic          ien_q, done_q;
  logic          eng_busy, eng_done, eng_zwe, go, mode_ok;
  logic [NW-1:0] nh_words;
  logic [MW-1:0] eng_xaddr, eng_yaddr, eng_zwaddr;
  word_t         eng_zwdata, x_q, z_q;

  // write-side decode
  logic [1:0]    w_region;
  logic [OW-1:0] w_off;
  logic          w_inwin, w_reg;
  logic [MW-1:0] w_idx;
  assign w_region = wr_addr[ADDR_W-1 -: 2];
  assign w_off    = wr_addr[OW-1:0];
  assign w_inwin  = ((w_off >> (MW + 2)) == '0) && (w_off[1:0] == 2'b00);
  assign w_idx    = w_off[2 +: MW];
  assign w_reg    = wr_en && (w_region == REGION_REG) && !eng_busy;

  // read-side decode
  logic [1:0]    r_region, sel_q;
  logic [OW-1:0] r_off;
  logic [MW-1:0] r_idx;
  word_t         reg_val, regrd_q;
  assign r_region = rd_addr[ADDR_W-1 -: 2];
  assign r_off    = rd_addr[OW-1:0];
  assign r_idx    = r_off[2 +: MW];

  assign mode_ok  = mode_q[3] && (int'(mode_q[2:0]) < MAX_SEGS);
  assign go       = w_reg && (w_off == OFF_GO) && wr_data[0] && mode_ok;
  assign nh_words = NW'((32'(mode_q[2:0]) + 32'd1) * 32'(SEG_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ien_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (w_reg && w_off == OFF_MODE) mode_q <= wr_data[3:0];
      if (w_reg && w_off == OFF_IEN)  ien_q  <= wr_data[0];
      if (go)
        done_q <= 1'b0;
      else if (eng_done)
        done_q <= 1'b1;
      else if (w_reg && w_off == OFF_DONE && wr_data[0])
        done_q <= 1'b0;
    end
  end

  assign irq = done_q & ien_q;

  always_comb begin
    reg_val = '0;
    if (r_region == REGION_REG) begin
      unique case (r_off)
        OFF_IEN:  reg_val = {31'd0, ien_q};
        OFF_MODE: reg_val = {28'd0, mode_q};
        OFF_DONE: reg_val = {31'd0, done_q};
        default:  reg_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= REGION_REG;
      regrd_q <= '0;
    end else begin
      sel_q   <= r_region;
      regrd_q <= reg_val;
    end
  end

  always_comb begin
    unique case (sel_q)
      REGION_X: rd_data = x_q;
      REGION_Z: rd_data = z_q;
      default:  rd_data = regrd_q;
    endcase
  end

  // operand and result memories
  logic          x_we, z_we;
  logic [MW-1:0] z_waddr;
  word_t         z_wdata;
  assign x_we    = wr_en && (w_region == REGION_X) && w_inwin && !eng_busy;
  assign z_we    = eng_busy ? eng_zwe : (wr_en && (w_region == REGION_Z) && w_inwin);
  assign z_waddr = eng_busy ? eng_zwaddr : w_idx;
  assign z_wdata = eng_busy ? eng_zwdata : wr_data;

  bigmul_wordram #(.DEPTH(MEM_WORDS), .AW(MW)) u_xram (
    .clk(clk), .we(x_we), .waddr(w_idx), .wdata(wr_data),
    .raddr(eng_busy ? eng_xaddr : r_idx), .rdata(x_q)
  );

  bigmul_wordram #(.DEPTH(MEM_WORDS), .AW(MW)) u_zram (
    .clk(clk), .we(z_we), .waddr(z_waddr), .wdata(z_wdata),
    .raddr(eng_busy ? eng_yaddr : r_idx), .rdata(z_q)
  );

  bigmul_engine #(.MEM_WORDS(MEM_WORDS), .MW(MW), .NW(NW)) u_eng (
    .clk(clk), .rst(rst), .start(go), .nh_words(nh_words),
    .x_rdata(x_q), .y_rdata(z_q),
    .x_raddr(eng_xaddr), .y_raddr(eng_yaddr),
    .z_we(eng_zwe), .z_waddr(eng_zwaddr), .z_wdata(eng_zwdata),
    .busy(eng_busy), .done(eng_done)
  );
endmodule

// File: rtl/bigmul_accel_chk.sv
module bigmul_accel_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              go,
  input logic              eng_done,
  input logic              eng_zwe,
  input logic              flag,
  input logic              irq,
  input logic [3:0]        mode,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data
);
  assert_go_busy_R4: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);

  assert_start_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == ADDR_W'(16)) |-> (rd_data == 32'd0));

  assert_flag_after_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(eng_done));

  assert_copy_before_done_R3: assert property (@(posedge clk) disable iff (rst)
    eng_done |-> $past(eng_zwe));

  assert_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);

  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode));
endmodule

bind bigmul_accel bigmul_accel_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(eng_busy), .go(go), .eng_done(eng_done),
  .eng_zwe(eng_zwe), .flag(done_q), .irq(irq), .mode(mode_q),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_bigmul_accel.sv
`timescale 1ns/1ps
module sim_bigmul_accel;
  localparam int SEGW = 4;
  localparam int MAXS = 2;
  localparam int AW   = 12;
  localparam int MEMW = SEGW * MAXS;
  localparam logic [AW-1:0] A_IEN  = 12'h008;
  localparam logic [AW-1:0] A_MODE = 12'h00C;
  localparam logic [AW-1:0] A_GO   = 12'h010;
  localparam logic [AW-1:0] A_DONE = 12'h014;
  localparam logic [AW-1:0] X_BASE = 12'h400;
  localparam logic [AW-1:0] Z_BASE = 12'h800;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, irq;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] xw [MEMW];
  logic [31:0] zw [MEMW];

  always #2.5 clk = ~clk;

  bigmul_accel #(.SEG_WORDS(SEGW), .MAX_SEGS(MAXS), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_done();
    logic [31:0] f;
    int tries = 0;
    f = 0;
    while (f[0] !== 1'b1 && tries < 1000) begin
      bus_rd(A_DONE, f);
      tries++;
    end
    if (tries >= 1000) chk("R5 completion timeout", 32'd0, 32'd1);
  endtask

  function automatic logic [31:0] opw(int pat, int k, int top);
    case (pat)
      1: return 32'hFFFF_FFFF;
      2: return (k == top) ? 32'h8000_0000 : 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  task automatic do_op(input int seg, input int pat, input bit junk, input bit poke);
    int n, nh;
    logic [32*MEMW-1:0] xv, yv, pv;
    logic [31:0] d;
    n = (seg + 1) * SEGW / 2;
    nh = 2 * n;
    for (int k = 0; k < MEMW; k++) begin
      if (k < n) xw[k] = opw(pat, k, n - 1);
      else       xw[k] = junk ? $urandom : 32'd0;
      if (k < n)       zw[k] = junk ? $urandom : 32'd0;
      else if (k < nh) zw[k] = opw(pat, k - n, n - 1);
      else             zw[k] = $urandom;
    end
    for (int k = 0; k < MEMW; k++) begin
      bus_wr(X_BASE + AW'(4 * k), xw[k]);
      bus_wr(Z_BASE + AW'(4 * k), zw[k]);
    end
    bus_wr(A_MODE, 32'(8 + seg));
    bus_wr(A_GO, 32'd1);
    if (poke) begin
      bus_wr(X_BASE, ~xw[0]);
      bus_wr(Z_BASE + AW'(4 * n), ~zw[n]);
      bus_wr(A_MODE, 32'd8);
      bus_wr(A_GO, 32'd1);
    end
    wait_done();
    xv = '0; yv = '0;
    for (int k = 0; k < n; k++) begin
      xv[32*k +: 32] = xw[k];
      yv[32*k +: 32] = zw[n + k];
    end
    pv = xv * yv;
    for (int k = 0; k < nh; k++) begin
      bus_rd(Z_BASE + AW'(4 * k), d);
      chk(junk ? "R9 product with junk" : (poke ? "R7 product after busy writes" : "R3 product word"),
          d, pv[32*k +: 32]);
    end
    for (int k = nh; k < MEMW; k++) begin
      bus_rd(Z_BASE + AW'(4 * k), d);
      chk("R9 Z above length kept", d, zw[k]);
    end
    bus_rd(A_MODE, d);
    chk("R2 mode retained", d, 32'(8 + seg));
    if (poke) begin
      bus_rd(X_BASE, d);
      chk("R7 X write ignored while busy", d, xw[0]);
    end
    bus_rd(A_DONE, d);
    chk("R5 flag set", d, 32'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk("watchdog", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240613));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_rd(A_MODE, d); chk("R1 mode reset", d, 32'd0);
    bus_rd(A_DONE, d); chk("R1 flag reset", d, 32'd0);
    bus_rd(A_IEN, d);  chk("R1 enable reset", d, 32'd1);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    bus_rd(12'h000, d); chk("R10 unmapped offset", d, 32'd0);

    // R8 invalid codes
    bus_wr(A_MODE, 32'd0); bus_wr(A_GO, 32'd1);
    repeat (60) @(negedge clk);
    bus_rd(A_DONE, d); chk("R8 bit3 clear ignored", d, 32'd0);
    bus_wr(A_MODE, 32'(8 + MAXS)); bus_wr(A_GO, 32'd1);
    repeat (60) @(negedge clk);
    bus_rd(A_DONE, d); chk("R8 length too large ignored", d, 32'd0);

    // directed cases
    do_op(0, 1, 1'b0, 1'b0);
    chk("R6 irq with flag", {31'd0, irq}, 32'd1);
    bus_rd(A_GO, d); chk("R4 start reads zero", d, 32'd0);
    bus_wr(A_DONE, 32'd1);
    bus_rd(A_DONE, d); chk("R5 write one clears", d, 32'd0);
    chk("R6 irq low after clear", {31'd0, irq}, 32'd0);
    do_op(1, 1, 1'b0, 1'b0);
    do_op(1, 2, 1'b0, 1'b0);
    do_op(1, 0, 1'b0, 1'b1);
    do_op(0, 0, 1'b1, 1'b0);
    do_op(1, 0, 1'b1, 1'b0);

    // R5 new start clears flag; R6 enable gating
    bus_wr(A_IEN, 32'd0);
    bus_wr(A_GO, 32'd1);
    bus_rd(A_DONE, d); chk("R5 start clears flag", d, 32'd0);
    wait_done();
    chk("R6 irq masked", {31'd0, irq}, 32'd0);
    bus_wr(A_IEN, 32'd1);
    chk("R6 irq unmasked", {31'd0, irq}, 32'd1);

    // random cases
    for (int t = 0; t < 12; t++) do_op(int'($urandom % MAXS), 0, t[0], 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule